// File: doc/BRIEF.md
# Low-Power Compare/Reload Timer

This block is a 16-bit up-counter with a small synchronous register port and a single interrupt line. A prescaler divides an incoming timer tick by a power of two. The counter starts at zero and advances once per prescaled tick. After it reaches the reload value, the next count takes it back to zero. Two sticky match flags record that the counter has taken the compare value or the reload value. A pending write to the compare or reload register reaches the counting logic only after a short delay measured in ticks, and an "update OK" flag reports when the new value has taken effect.

Software configures the timer while it is disabled. It then sets the enable bit together with a start command. It watches the interrupt line or polls the status register, and clears flags by writing ones. Clock-source selection is outside the block. The chosen source appears as the `tick_en` qualifier, one cycle wide.

Register map (3-bit address). 0 control: bit0 enable, bit1 start (write) / running (read). 1 config: bits[2:0] prescaler. 2 reload. 3 compare. 4 interrupt enable: bit0 compare, bit1 reload. 5 status: bit0 compare match, bit1 reload match, bit2 compare update OK, bit3 reload update OK. 6 clear (write-one, same bit positions as status). 7 counter value (read).

Top module: `lp_cmp_timer`

## Requirements
- R1: After reset the reload register reads 0xFFFF, and compare, counter, status, interrupt enable and control all read 0. `irq` is 0. Read data appears on `reg_rdata` one cycle after the address is presented.
- R2: The counter advances only while running. Running is set by a control write with bit0=1 and bit1=1. A control write with bit0=1 and bit1=0 leaves the counter idle at 0.
- R3: With prescaler code p (0 to 7), the counter advances once every 2^p qualified ticks (`tick_en`=1).
- R4: Each advance moves the counter to value+1, or to 0 when it currently equals the active reload value. The reload-match flag (status bit1) sets on the advance that makes the counter equal to the active reload value.
- R5: The compare-match flag (status bit0) sets on the advance that makes the counter equal to the active compare value. This happens only when compare is strictly less than reload; otherwise the flag is never raised.
- R6: Writing 1 to a bit of the clear register (address 6) clears that status bit, and writing 0 leaves it unchanged. If a set and a clear occur in the same cycle, the set wins.
- R7: A compare or reload write reads back at once. The counting logic keeps using the old value until the second qualified tick after the write. On that tick the new value takes effect and the matching update-OK flag (status bit2 for compare, bit3 for reload) sets. A further write restarts the wait.
- R8: Writes to the interrupt-enable register take effect only while enable is 0. Writes made while enable is 1 are ignored.
- R9: A control write with bit0=0 stops counting and returns the counter and the prescale divider to 0. Reload, compare, prescaler, interrupt-enable and status contents are kept.
- R10: `irq` is registered. It is 1 in the cycle after one in which (compare flag AND enable bit0) OR (reload flag AND enable bit1) holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer tick qualifier from the selected clock source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for the previous cycle's address |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `tick_en` and the register port are driven synchronously and are free of X after reset. They also assume that software does not change the prescaler code while running, which would let the divider pass its new terminal value. The stimulus changes the prescaler only while the timer is disabled. It runs the tick both every cycle and every third cycle, and it writes the compare register mid-run, so that the delayed update lands between counts. It also sets compare equal to reload to show that the compare flag stays silent.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int ADDR_W = 3;
  localparam int FLAG_N = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CFG    = 3'd1,
    A_RELOAD = 3'd2,
    A_CMP    = 3'd3,
    A_IER    = 3'd4,
    A_STATUS = 3'd5,
    A_CLEAR  = 3'd6,
    A_COUNT  = 3'd7
  } lpt_addr_e;

  localparam int F_CMPM  = 0;
  localparam int F_RLDM  = 1;
  localparam int F_CMPOK = 2;
  localparam int F_RLDOK = 3;
endpackage

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  input  logic [PSC_W-1:0] psc,
  output logic             step
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] last;

  always_comb begin
    span = ((DIV_W+1)'(1) << psc) - (DIV_W+1)'(1);
    last = span[DIV_W-1:0];
  end

  assign step = run && tick && !clear && (div_q == last);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      div_q <= '0;
    end else if (run && tick) begin
      div_q <= (div_q == last) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/lpt_sync_update.sv
module lpt_sync_update #(
  parameter int          W          = 16,
  parameter int          SYNC_TICKS = 2,
  parameter logic [W-1:0] RST_VAL   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         done
);
  localparam int CW = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

  logic          pend;
  logic [CW-1:0] wait_q;

  assign done = pend && tick && !wr && (wait_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= RST_VAL;
      active <= RST_VAL;
      pend   <= 1'b0;
      wait_q <= '0;
    end else if (wr) begin
      shadow <= wdata;
      pend   <= 1'b1;
      wait_q <= '0;
    end else if (pend && tick) begin
      if (wait_q == LAST) begin
        active <= shadow;
        pend   <= 1'b0;
      end else begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] compare,
  output logic [CNT_W-1:0] cnt,
  output logic             rld_hit,
  output logic             cmp_hit
);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = (cnt == reload) ? '0 : cnt + 1'b1;
    rld_hit = step && (cnt_nxt == reload);
    cmp_hit = step && (cnt_nxt == compare) && (compare < reload);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/lp_cmp_timer.sv
module lp_cmp_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PSC_W      = 3,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  logic             en, run;
  logic [PSC_W-1:0] psc;
  logic [1:0]       ier;
  logic [FLAG_N-1:0] flags, flag_set, flag_clr;
  logic             wr_ctrl, wr_cfg, wr_rld, wr_cmp, wr_ier, wr_clr, dis_now;
  logic             step, rld_hit, cmp_hit, rld_done, cmp_done;
  logic [CNT_W-1:0] cnt, rld_sh, rld_act, cmp_sh, cmp_act;
  logic [CNT_W-1:0] rd_mux;

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    wr_cfg  = reg_wr && (reg_addr == A_CFG);
    wr_rld  = reg_wr && (reg_addr == A_RELOAD);
    wr_cmp  = reg_wr && (reg_addr == A_CMP);
    wr_ier  = reg_wr && (reg_addr == A_IER);
    wr_clr  = reg_wr && (reg_addr == A_CLEAR);
    dis_now = wr_ctrl && !reg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      run <= 1'b0;
      psc <= '0;
      ier <= '0;
    end else begin
      if (wr_ctrl) begin
        en <= reg_wdata[0];
        if (!reg_wdata[0])     run <= 1'b0;
        else if (reg_wdata[1]) run <= 1'b1;
      end
      if (wr_cfg)         psc <= reg_wdata[PSC_W-1:0];
      if (wr_ier && !en)  ier <= reg_wdata[1:0];
    end
  end

  lpt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .clear(dis_now), .run(run),
    .tick(tick_en), .psc(psc), .step(step)
  );

  lpt_sync_update #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL({CNT_W{1'b1}})) u_rld (
    .clk(clk), .rst(rst), .tick(tick_en), .wr(wr_rld), .wdata(reg_wdata),
    .shadow(rld_sh), .active(rld_act), .done(rld_done)
  );

  lpt_sync_update #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) u_cmp (
    .clk(clk), .rst(rst), .tick(tick_en), .wr(wr_cmp), .wdata(reg_wdata),
    .shadow(cmp_sh), .active(cmp_act), .done(cmp_done)
  );

  lpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(dis_now), .step(step),
    .reload(rld_act), .compare(cmp_act),
    .cnt(cnt), .rld_hit(rld_hit), .cmp_hit(cmp_hit)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[F_CMPM]  = cmp_hit;
    flag_set[F_RLDM]  = rld_hit;
    flag_set[F_CMPOK] = cmp_done;
    flag_set[F_RLDOK] = rld_done;
    flag_clr          = wr_clr ? reg_wdata[FLAG_N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~flag_clr) | flag_set;
      irq   <= |(flags[1:0] & ier);
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:   rd_mux = CNT_W'({run, en});
      A_CFG:    rd_mux = CNT_W'(psc);
      A_RELOAD: rd_mux = rld_sh;
      A_CMP:    rd_mux = cmp_sh;
      A_IER:    rd_mux = CNT_W'(ier);
      A_STATUS: rd_mux = CNT_W'(flags);
      A_CLEAR:  rd_mux = '0;
      default:  rd_mux = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/lpt_checker.sv
module lpt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             en,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [3:0]       flags,
  input logic [1:0]       ier,
  input logic             irq
);
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !en |-> (cnt == '0));

  p_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> ($past(run) || cnt == '0));

  p_step_shape_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

  p_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt) && cnt != '0) |-> $past(tick_en));

  p_ier_locked_r8: assert property (@(posedge clk) disable iff (rst)
    en |=> $stable(ier));

  p_irq_src_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(flags[1:0] & ier)));

  p_ok_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(flags[2]) || $rose(flags[3])) |-> $past(tick_en));
endmodule

bind lp_cmp_timer lpt_checker #(.CNT_W(CNT_W)) u_lpt_checker (
  .clk(clk), .rst(rst), .tick_en(tick_en), .en(en), .run(run),
  .cnt(cnt), .flags(flags), .ier(ier), .irq(irq)
);

// File: tb/test_lp_cmp_timer.sv
module test_lp_cmp_timer;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_mode = 0;
  int phase = 0;

  always #10 clk = ~clk;

  lp_cmp_timer i_lp_cmp_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference model
  int m_en, m_run, m_psc, m_ier, m_flags, m_cnt, m_div;
  int m_rld_sh, m_rld_act, m_rld_pend, m_rld_wait;
  int m_cmp_sh, m_cmp_act, m_cmp_pend, m_cmp_wait;
  int m_rd, m_irq;

  function automatic int model_read(int a);
    case (a)
      0: return m_en + 2 * m_run;
      1: return m_psc;
      2: return m_rld_sh;
      3: return m_cmp_sh;
      4: return m_ier;
      5: return m_flags;
      6: return 0;
      default: return m_cnt;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R2";
      1: return "R3";
      2, 3: return "R7";
      4: return "R8";
      5, 6: return "R6";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_run = 0; m_psc = 0; m_ier = 0; m_flags = 0; m_cnt = 0; m_div = 0;
      m_rld_sh = 16'hFFFF; m_rld_act = 16'hFFFF; m_rld_pend = 0; m_rld_wait = 0;
      m_cmp_sh = 0; m_cmp_act = 0; m_cmp_pend = 0; m_cmp_wait = 0;
      m_rd = 0; m_irq = 0;
    end else begin
      int set, clr, nirq, dis, stp, w;
      w = reg_wdata;
      m_rd = model_read(reg_addr);
      nirq = ((m_flags & 3 & m_ier) != 0) ? 1 : 0;
      set = 0; stp = 0;
      dis = (reg_wr && reg_addr == 0 && !reg_wdata[0]) ? 1 : 0;
      if (m_run != 0 && tick_en && dis == 0) begin
        if (m_div == (1 << m_psc) - 1) begin m_div = 0; stp = 1; end
        else m_div = (m_div + 1) % 128;
      end
      if (stp != 0) begin
        m_cnt = (m_cnt == m_rld_act) ? 0 : (m_cnt + 1) % 65536;
        if (m_cnt == m_rld_act) set |= 2;
        if (m_cnt == m_cmp_act && m_cmp_act < m_rld_act) set |= 1;
      end
      if (reg_wr && reg_addr == 3) begin
        m_cmp_sh = w; m_cmp_pend = 1; m_cmp_wait = 0;
      end else if (m_cmp_pend != 0 && tick_en) begin
        if (m_cmp_wait == SYNC - 1) begin m_cmp_act = m_cmp_sh; m_cmp_pend = 0; set |= 4; end
        else m_cmp_wait++;
      end
      if (reg_wr && reg_addr == 2) begin
        m_rld_sh = w; m_rld_pend = 1; m_rld_wait = 0;
      end else if (m_rld_pend != 0 && tick_en) begin
        if (m_rld_wait == SYNC - 1) begin m_rld_act = m_rld_sh; m_rld_pend = 0; set |= 8; end
        else m_rld_wait++;
      end
      clr = (reg_wr && reg_addr == 6) ? (w & 15) : 0;
      m_flags = (m_flags & ~clr) | set;
      if (reg_wr && reg_addr == 4 && m_en == 0) m_ier = w & 3;
      if (reg_wr && reg_addr == 1) m_psc = w & 7;
      if (reg_wr && reg_addr == 0) begin
        m_en = w & 1;
        if ((w & 1) == 0) begin m_run = 0; m_cnt = 0; m_div = 0; end
        else if ((w & 2) != 0) m_run = 1;
      end
      m_irq = nirq;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(tag_of(reg_addr), reg_rdata, m_rd);
      chk("R10", irq, m_irq);
    end
  end

  // tick generator: every cycle or every third cycle
  always @(negedge clk) begin
    phase <= (phase + 1) % 3;
    tick_en <= (tick_mode == 0) ? 1'b1 : (phase == 2);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd7;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a);
    @(negedge clk);
    v = reg_rdata;
    reg_addr = 3'd7;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int v;
    reg_addr = 3'd7;
    idle(5);
    rst = 1'b0;
    // R1 reset values
    rd(2, v); chk("R1 reload", v, 16'hFFFF);
    rd(3, v); chk("R1 compare", v, 0);
    rd(7, v); chk("R1 counter", v, 0);
    rd(5, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);
    // R8 enable writes accepted while disabled
    wr(4, 3); rd(4, v); chk("R8 ier while disabled", v, 3);
    // R7 reload update handshake
    wr(2, 5); rd(2, v); chk("R7 readback", v, 5);
    idle(3); rd(5, v); chk("R7 reload ok", v & 8, 8);
    wr(3, 2); idle(3); rd(5, v); chk("R7 compare ok", v & 4, 4);
    wr(6, 12); rd(5, v); chk("R6 clear ok flags", v, 0);
    // R2 enable without start stays idle
    wr(1, 0); wr(0, 1); idle(10);
    rd(7, v); chk("R2 idle without start", v, 0);
    wr(0, 3); idle(40);
    rd(5, v); chk("R4 R5 match flags", v & 3, 3);
    chk("R10 irq raised", irq, 1);
    // R8 ignored while enabled
    wr(4, 0); rd(4, v); chk("R8 ier locked", v, 3);
    // R6 writing zero has no effect
    wr(6, 0); rd(5, v); chk("R6 zero write", v & 3, 3);
    wr(6, 3); idle(4);
    // R9 disable clears counter, keeps registers
    wr(0, 0); rd(7, v); chk("R9 counter cleared", v, 0);
    rd(2, v); chk("R9 reload kept", v, 5);
    rd(4, v); chk("R9 ier kept", v, 3);
    // R3 prescaler patterns
    wr(1, 2); wr(0, 3); idle(60);
    wr(0, 0); wr(2, 3); wr(1, 7); wr(0, 3); idle(1100);
    wr(0, 0); tick_mode = 1; wr(1, 1); wr(2, 9); wr(0, 3); idle(30);
    wr(3, 4); idle(120);
    // R5 compare not below reload never raises the compare flag
    wr(0, 0); tick_mode = 0; wr(1, 0); wr(2, 7); wr(3, 7); idle(5);
    wr(6, 15); wr(0, 3); idle(200);
    rd(5, v); chk("R5 compare equal reload", v & 1, 0);
    chk("R4 reload flag", v & 2, 2);
    wr(0, 0); idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule